// File: doc/BRIEF.md
# Serial Pixel Frame Transmitter

This block sends one-bit image pixels over an asynchronous serial line. Each baud tick it drives exactly one bit. A frame is ten bit slots: a low start bit, eight data bits with the earliest pixel first, and a high stop bit. While transmit enable stays high, frames follow one another with no gap. When transmit enable is low the line rests high.

The data bits do not come from a parallel byte. A companion fetch unit reads one pixel at a time. The transmitter pulses `fetch_ok` when a new pixel is needed for the next slot, and the fetch unit puts that pixel on `pix_in` before the following tick. The transmitter also handles two special cases:

- **End of row.** When the fetch unit reports the end of a row, fetching stops. The last pixel is repeated until the frame is full, so no frame carries pixels from two rows. The stop slot then issues one extra fetch that only advances the row, and its pixel is never sent.
- **Wide mode.** Each pixel is sent twice, which doubles the horizontal size of the image.

Top module: `sptx_top`

## Requirements
- R1: While `tx_en` is low, from the next clock `ser_out` is 1, `slot_pos` is 15 (idle), `busy` is 0 and `fetch_ok` is 0. Baud ticks are ignored.
- R2: The first baud tick after `tx_en` goes high sets `slot_pos` to 0 and drives `ser_out` low (the start bit).
- R3: Each baud tick advances one slot: 0 is start, 1 to 8 are data bits 0 to 7, 9 is stop (`ser_out` high), and after 9 comes 0 again. `ser_out` changes only in the clock of a tick or when `tx_en` falls.
- R4: Outside the other modes, data slot k+1 carries the pixel returned by the fetch issued at the tick that entered slot k. That is, pixels go out least significant bit first, in fetch order. The pixel must be on `pix_in` by the next tick.
- R5: `fetch_ok` is high for exactly one clock, starting in the clock after a tick. It is never high while `slot_pos` is 8 (the last data slot).
- R6: Once `row_end` is sampled high at a tick that enters any of slots 0 to 8, no further data fetch is issued in that frame, even if `row_end` later falls. The remaining data slots repeat the last fetched pixel.
- R7: If the row end was seen, the tick entering slot 9 issues one dummy `fetch_ok`. The pixel it returns is not transmitted: the stop bit is 1, and the held pixel is unchanged.
- R8: With `wide_mode` high, fetches are issued only for data bits 0, 2, 4 and 6. Bits 1, 3, 5 and 7 repeat the previous bit. This alternation restarts in every frame.
- R9: `busy` is 1 whenever `slot_pos` is 0 to 9.
- R10: Dropping `tx_en` in mid-frame aborts the frame. The next rise of `tx_en` starts again with a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-clock strobe per bit time |
| tx_en | input | 1 | Transmit enable; low holds the block idle |
| pix_in | input | 1 | Pixel returned by the fetch unit |
| row_end | input | 1 | Column address at the end of the row |
| wide_mode | input | 1 | Send every pixel twice |
| ser_out | output | 1 | Registered serial line, idle high |
| fetch_ok | output | 1 | One-clock request for the next pixel |
| slot_pos | output | 4 | Current slot: 0 start, 1-8 data, 9 stop, 15 idle |
| busy | output | 1 | A frame is in progress |

## Verification
The assertions take for granted that:
- `baud_tick` is never high on two consecutive clocks, so a fetch pulse can end before the next tick arrives.
- The fetch unit returns its pixel within one bit time.

The bench keeps to both. It spaces ticks four clocks apart and answers each `fetch_ok` at once. It changes `pix_in` to a wrong value whenever no fetch is outstanding, so a design that sampled the pin on a repeated slot would be caught. It raises `row_end` only between ticks and drops it in mid-frame, which tests that the row-end state is latched.

// File: rtl/sptx_pkg.sv
// Package: shared slot classification for the serial pixel transmitter.
// Assumes slot 0 is start, 1..DATA_BITS are data, DATA_BITS+1 is stop.
package sptx_pkg;

    typedef enum logic [1:0] {
        SK_START = 2'd0,
        SK_DATA  = 2'd1,
        SK_STOP  = 2'd2,
        SK_IDLE  = 2'd3
    } slot_kind_e;

    // Classify a slot number for a frame with the given data width.
    function automatic slot_kind_e kind_of(input int unsigned slot,
                                           input int unsigned data_bits);
        if (slot == 0)                return SK_START;
        else if (slot <= data_bits)   return SK_DATA;
        else if (slot == data_bits+1) return SK_STOP;
        else                          return SK_IDLE;
    endfunction

endpackage

// File: rtl/sptx_slot_counter.sv
// Module: bit-slot counter. Holds the idle code while transmit is off and
// steps one slot per baud tick, wrapping stop back to start.
// Assumes baud_tick is a single-clock strobe.
module sptx_slot_counter #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned SLOT_W    = $clog2(DATA_BITS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              step
);
    localparam logic [SLOT_W-1:0] IDLE_CODE = '1;
    localparam logic [SLOT_W-1:0] STOP_CODE = SLOT_W'(DATA_BITS + 1);

    // Next slot: idle and stop both lead to start.
    always_comb begin
        if (slot_q == IDLE_CODE || slot_q == STOP_CODE) slot_nxt = '0;
        else                                            slot_nxt = slot_q + SLOT_W'(1);
    end

    assign step = baud_tick & tx_en;

    // Slot register: reset or disabled forces idle, otherwise advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         slot_q <= IDLE_CODE;
        else if (!tx_en)    slot_q <= IDLE_CODE;
        else if (baud_tick) slot_q <= slot_nxt;
    end

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> slot_q == IDLE_CODE);

    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && slot_q != IDLE_CODE && slot_q != STOP_CODE)
        |=> slot_q == $past(slot_q) + SLOT_W'(1));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && slot_q == STOP_CODE) |=> slot_q == '0);

endmodule

// File: rtl/sptx_fetch_ctrl.sv
// Module: fetch decision. At each tick it decides whether the slot after
// the one being entered needs a fresh pixel, and applies the row-end latch,
// the dummy stop-slot fetch and the wide-mode alternation.
// Assumes ticks are at least two clocks apart.
module sptx_fetch_ctrl #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned SLOT_W    = $clog2(DATA_BITS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              step,
    input  logic [SLOT_W-1:0] slot_nxt,
    input  logic              row_end,
    input  logic              wide_mode,
    output logic              fetch_ok,
    output logic              fetch_pend
);
    localparam logic [SLOT_W-1:0] LAST_PRE  = SLOT_W'(DATA_BITS);
    localparam logic [SLOT_W-1:0] STOP_CODE = SLOT_W'(DATA_BITS + 1);

    logic row_lock;
    logic at_start, feeds_data, blocked, fresh, dummy;

    // Decide what the coming slot requires.
    always_comb begin
        at_start   = (slot_nxt == '0);
        feeds_data = (slot_nxt < LAST_PRE);
        blocked    = row_end | (row_lock & ~at_start);
        fresh      = feeds_data & ~blocked & ~(wide_mode & slot_nxt[0]);
        dummy      = (slot_nxt == STOP_CODE) & blocked;
    end

    // Fetch strobe, capture marker and row-end latch, all updated on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            fetch_ok   <= 1'b0;
            fetch_pend <= 1'b0;
            row_lock   <= 1'b0;
        end else if (step) begin
            fetch_ok   <= fresh | dummy;
            fetch_pend <= fresh;
            if (at_start)                 row_lock <= row_end;
            else if (slot_nxt <= LAST_PRE) row_lock <= row_lock | row_end;
        end else begin
            fetch_ok <= 1'b0;
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ok |=> !fetch_ok);

    a_r6_latched_block: assert property (@(posedge clk) disable iff (!rst_n)
        (step && row_lock && feeds_data && !at_start) |=> !fetch_ok);

endmodule

// File: rtl/sptx_bit_driver.sv
// Module: serial line register. Drives start, data or stop on each tick,
// holding the last fetched pixel for repeated slots.
// Assumes pix_in is valid at any tick that follows an issued fetch.
module sptx_bit_driver #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned SLOT_W    = $clog2(DATA_BITS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              step,
    input  logic [SLOT_W-1:0] slot_nxt,
    input  logic              fetch_pend,
    input  logic              pix_in,
    output logic              ser_out
);
    import sptx_pkg::*;

    logic       pix_hold;
    slot_kind_e kind;

    // Classify the slot being entered.
    always_comb kind = kind_of(32'(slot_nxt), DATA_BITS);

    // Line and pixel-hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out  <= 1'b1;
            pix_hold <= 1'b0;
        end else if (!tx_en) begin
            ser_out <= 1'b1;
        end else if (step) begin
            unique case (kind)
                SK_START: ser_out <= 1'b0;
                SK_DATA: begin
                    ser_out <= fetch_pend ? pix_in : pix_hold;
                    if (fetch_pend) pix_hold <= pix_in;
                end
                default:  ser_out <= 1'b1;
            endcase
        end
    end

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> ser_out);

    a_r3_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !step) |=> $stable(ser_out));

endmodule

// File: rtl/sptx_top.sv
// Module: serial pixel frame transmitter top. Ties the slot counter, fetch
// decision and line driver together and exports frame status.
// Assumes baud_tick strobes are at least two clocks apart.
module sptx_top #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned SLOT_W    = $clog2(DATA_BITS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              pix_in,
    input  logic              row_end,
    input  logic              wide_mode,
    output logic              ser_out,
    output logic              fetch_ok,
    output logic [SLOT_W-1:0] slot_pos,
    output logic              busy
);
    localparam logic [SLOT_W-1:0] IDLE_CODE = '1;
    localparam logic [SLOT_W-1:0] STOP_CODE = SLOT_W'(DATA_BITS + 1);
    localparam logic [SLOT_W-1:0] LAST_DATA = SLOT_W'(DATA_BITS);

    logic [SLOT_W-1:0] slot_q, slot_nxt;
    logic              step, fetch_pend;

    sptx_slot_counter #(.DATA_BITS(DATA_BITS), .SLOT_W(SLOT_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .slot_q(slot_q), .slot_nxt(slot_nxt), .step(step)
    );

    sptx_fetch_ctrl #(.DATA_BITS(DATA_BITS), .SLOT_W(SLOT_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .step(step),
        .slot_nxt(slot_nxt), .row_end(row_end), .wide_mode(wide_mode),
        .fetch_ok(fetch_ok), .fetch_pend(fetch_pend)
    );

    sptx_bit_driver #(.DATA_BITS(DATA_BITS), .SLOT_W(SLOT_W)) u_line (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .step(step),
        .slot_nxt(slot_nxt), .fetch_pend(fetch_pend), .pix_in(pix_in),
        .ser_out(ser_out)
    );

    // Status outputs.
    assign slot_pos = slot_q;
    assign busy     = (slot_q != IDLE_CODE);

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == '0) |-> !ser_out);

    a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == STOP_CODE) |-> ser_out);

    a_r5_none_before_stop: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ok |-> slot_q != LAST_DATA);

    a_r1_no_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fetch_ok);

endmodule

// File: tb/sptx_top_tb.sv
module sptx_top_tb;
    logic       clk = 1'b0;
    logic       rst_n, baud_tick, tx_en, pix_in, row_end, wide_mode;
    logic       ser_out, fetch_ok, busy;
    logic [3:0] slot_pos;

    int checks = 0;
    int fails  = 0;
    logic [15:0] pat = 16'hB2E5;
    int   pidx = 0;
    logic exp_hold = 1'b0;

    always #10 clk = ~clk;

    sptx_top u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .pix_in(pix_in), .row_end(row_end), .wide_mode(wide_mode),
        .ser_out(ser_out), .fetch_ok(fetch_ok), .slot_pos(slot_pos), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One baud tick; samples after the edge, then checks the gap clocks (R3, R5).
    task automatic do_tick(output logic s, output logic f);
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        s = ser_out;
        f = fetch_ok;
        @(negedge clk);
        check("R5 pulse ends", int'(fetch_ok), 0);
        check("R3 line quiet", int'(ser_out), int'(s));
        @(negedge clk);
    endtask

    // Run one full frame; expected values from R2-R9.
    task automatic run_frame(input string tag, input logic wide, input int rowend_at);
        logic s, f, pend_exp, pend_val, blocked, exp_f, exp_s;
        pend_exp = 1'b0;
        pend_val = 1'b0;
        wide_mode = wide;
        for (int sl = 0; sl < 10; sl++) begin
            if (rowend_at >= 0 && sl == rowend_at + 1) row_end = 1'b1;
            if (rowend_at >= 0 && sl == rowend_at + 3) row_end = 1'b0;
            blocked = (rowend_at >= 0) && (sl > rowend_at);
            if (sl < 8)       exp_f = !blocked && !(wide && sl[0]);
            else if (sl == 9) exp_f = blocked;
            else              exp_f = 1'b0;
            if (sl == 0)      exp_s = 1'b0;
            else if (sl == 9) exp_s = 1'b1;
            else              exp_s = pend_exp ? pend_val : exp_hold;
            do_tick(s, f);
            check({tag, " R3 slot"}, int'(slot_pos), sl);
            check({tag, " R4/R6/R8 bit"}, int'(s), int'(exp_s));
            check({tag, " R5/R7/R8 fetch"}, int'(f), int'(exp_f));
            check({tag, " R9 busy"}, int'(busy), 1);
            if (sl >= 1 && sl <= 8 && pend_exp) exp_hold = pend_val;
            pend_exp = exp_f && (sl < 8);
            if (f) begin
                pix_in = pat[pidx % 16];
                pidx++;
                pend_val = pix_in;
            end else begin
                pix_in = ~pix_in;
            end
        end
        row_end = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset line", int'(ser_out), 1);
        check("R1 reset slot", int'(slot_pos), 15);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset fetch", int'(fetch_ok), 0);
    endtask

    task automatic t_idle();
        logic s, f;
        tx_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            do_tick(s, f);
            check("R1 idle line", int'(s), 1);
            check("R1 idle fetch", int'(f), 0);
            check("R1 idle slot", int'(slot_pos), 15);
        end
    endtask

    task automatic t_normal();
        tx_en = 1'b1;
        run_frame("R2 normal1", 1'b0, -1);
        run_frame("normal2", 1'b0, -1);
    endtask

    task automatic t_wide();
        run_frame("wide1", 1'b1, -1);
        run_frame("wide2", 1'b1, -1);
    endtask

    task automatic t_rowend();
        run_frame("row3", 1'b0, 3);
        run_frame("after_row", 1'b0, -1);
        run_frame("row_wide0", 1'b1, 0);
        run_frame("row7", 1'b0, 7);
    endtask

    task automatic t_abort();
        logic s, f;
        for (int i = 0; i < 3; i++) do_tick(s, f);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        check("R10 abort line", int'(ser_out), 1);
        check("R10 abort slot", int'(slot_pos), 15);
        check("R10 abort busy", int'(busy), 0);
        check("R10 abort fetch", int'(fetch_ok), 0);
        pix_in = ~pix_in;
        @(negedge clk) tx_en = 1'b1;
        run_frame("R10 restart", 1'b0, -1);
    endtask

    initial begin
        rst_n = 1'b0; baud_tick = 1'b0; tx_en = 1'b0;
        pix_in = 1'b0; row_end = 1'b0; wide_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_normal();
        t_wide();
        t_rowend();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule